// File: doc/BRIEF.md
# Pseudowire Ethernet Encapsulator with Fragmentation

This block sits on the ingress side of a packet transport node. It takes Ethernet frames from an attachment-circuit byte stream and turns each into one or more pseudowire packets ready for an MPLS tunnel. The leading preamble bytes and the trailing frame check sequence are discarded. The frame bytes between them are carried unchanged behind a 12-byte header: an outer tunnel label, an inner pseudowire label and a 32-bit control word.

The source supplies the frame length (preamble and FCS excluded) together with the start marker. When the frame is longer than the path MTU, the frame is split into fragments. Each fragment is a complete packet with both labels and its own control word. The control word marks the fragment's position and holds a sequence number that counts packets and never reads zero. Labels, traffic class and TTL come from configuration inputs. The MTU may be changed at any time but only takes hold at the next frame.

The output is a valid/ready byte stream with packet start and end markers. Backpressure from the output reaches the input directly while payload flows. The input is held off while a header is being sent.

Top module: `pw_frag_encap`

## Requirements
- R1: The first 8 bytes of an input frame, counted from the byte carrying `in_sop`, are preamble and are dropped. After the header, exactly `in_len` frame bytes follow in input order. All later input bytes, up to and including the one with `in_eop`, are dropped.
- R2: Every output packet begins with 12 header bytes, each 32-bit word most significant byte first, in this order: tunnel label word, pseudowire label word, control word. `out_sop` is high on the first header byte only.
- R3: A label word is {label[19:0], tc[2:0], bottom-of-stack, ttl[7:0]}. Bottom-of-stack is 0 in the tunnel word and 1 in the pseudowire word.
- R4: The control word has bits 31:24 zero, a fragment code in bits 23:22, bits 21:16 zero and the sequence number in bits 15:0.
- R5: The fragment code is 00 when `in_len` does not exceed the MTU. Otherwise it is 10 on the first fragment, 11 on intermediate fragments and 01 on the last fragment.
- R6: Every fragment except the last carries exactly MTU frame bytes; the last carries the remainder. `out_eop` is high on the final byte of each packet.
- R7: The first packet after reset carries sequence number 1, and every packet, including each fragment, carries the previous value plus one.
- R8: The sequence number never reads zero. After the all-ones value of `SEQ_W` bits it wraps to 1 (65535 to 1 at the default width).
- R9: The MTU is sampled with the frame's `in_sop` byte. A change of `cfg_mtu` during a frame does not alter that frame's fragmentation.
- R10: `in_ready` is low while header bytes are offered. A header byte offered with `out_ready` low stays on `out_data` with `out_valid` high until it is taken.
- R11: While payload flows, `in_ready` follows `out_ready` and `out_valid` follows `in_valid`. After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mtu | input | LEN_W | Largest fragment payload in bytes (nonzero) |
| cfg_tun_label | input | 20 | Tunnel label value |
| cfg_tun_tc | input | 3 | Tunnel traffic class |
| cfg_tun_ttl | input | 8 | Tunnel TTL |
| cfg_pw_label | input | 20 | Pseudowire label value |
| cfg_pw_tc | input | 3 | Pseudowire traffic class |
| cfg_pw_ttl | input | 8 | Pseudowire TTL |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | First preamble byte of a frame |
| in_eop | input | 1 | Last FCS byte of a frame |
| in_len | input | LEN_W | Frame length without preamble and FCS, valid with in_sop |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts byte |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First byte of a packet |
| out_eop | output | 1 | Last byte of a packet |

## Verification
Two things can coincide in one cycle: the last payload byte of a fragment and the decision to start the next header. On that byte the block must retire the input byte, close the packet with `out_eop` and switch to header mode, all while `out_ready` may drop. The bench provokes this by running multi-fragment frames under a periodic `out_ready` pattern. It judges the result by requiring an exact byte, start and end stream. It also requires that `in_ready` was low on every header byte and that no stalled byte changed. A mid-frame MTU change and a sequence wrap inside a long fragment train add the same overlap at the sequence counter.

// File: rtl/pw_frag_encap.sv
module pw_frag_encap #(
  parameter int LEN_W   = 16,
  parameter int SEQ_W   = 16,
  parameter int PRE_LEN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] cfg_mtu,
  input  logic [19:0]      cfg_tun_label,
  input  logic [2:0]       cfg_tun_tc,
  input  logic [7:0]       cfg_tun_ttl,
  input  logic [19:0]      cfg_pw_label,
  input  logic [2:0]       cfg_pw_tc,
  input  logic [7:0]       cfg_pw_ttl,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic [LEN_W-1:0] in_len,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_sop,
  output logic             out_eop
);
  localparam int PRE_W  = (PRE_LEN > 1) ? $clog2(PRE_LEN) : 1;
  localparam int HDR_N  = 12;
  localparam logic [SEQ_W-1:0] SEQ_MAX = '1;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_HDR, S_PAY, S_FCS} st_t;

  st_t              st;
  logic [PRE_W-1:0] pcnt;
  logic [3:0]       hcnt;
  logic [LEN_W-1:0] len_q, mtu_q, rem, frag_left;
  logic [SEQ_W-1:0] seq_q;

  logic        in_fire, out_fire, first, fits, hdr_done;
  logic [1:0]  code;
  logic [15:0] seq16;
  logic [95:0] hdr, hdr_sh;

  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;
  assign first    = (rem == len_q);
  assign fits     = (rem <= mtu_q);
  assign code     = first ? (fits ? 2'b00 : 2'b10) : (fits ? 2'b01 : 2'b11);
  assign seq16    = 16'(seq_q);
  assign hdr      = {cfg_tun_label, cfg_tun_tc, 1'b0, cfg_tun_ttl,
                     cfg_pw_label,  cfg_pw_tc,  1'b1, cfg_pw_ttl,
                     8'h00, code, 6'h00, seq16};
  assign hdr_sh   = hdr << {hcnt, 3'b000};
  assign hdr_done = (st == S_HDR) && out_fire && (hcnt == 4'(HDR_N - 1));

  assign in_ready  = (st == S_IDLE) || (st == S_PRE) || (st == S_FCS) ||
                     ((st == S_PAY) && out_ready);
  assign out_valid = (st == S_HDR) || ((st == S_PAY) && in_valid);
  assign out_data  = (st == S_HDR) ? hdr_sh[95:88] : in_data;
  assign out_sop   = (st == S_HDR) && (hcnt == 4'd0);
  assign out_eop   = (st == S_PAY) && (frag_left == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      pcnt      <= '0;
      hcnt      <= '0;
      len_q     <= '0;
      mtu_q     <= '0;
      rem       <= '0;
      frag_left <= '0;
      seq_q     <= SEQ_W'(1);
    end else begin
      case (st)
        S_IDLE: if (in_fire && in_sop) begin
          len_q <= in_len;
          rem   <= in_len;
          mtu_q <= cfg_mtu;
          pcnt  <= PRE_W'(1);
          st    <= S_PRE;
        end
        S_PRE: if (in_fire) begin
          if (pcnt == PRE_W'(PRE_LEN - 1)) begin
            hcnt <= '0;
            st   <= S_HDR;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        S_HDR: if (out_fire) begin
          if (hdr_done) begin
            frag_left <= fits ? rem : mtu_q;
            seq_q     <= (seq_q == SEQ_MAX) ? SEQ_W'(1) : seq_q + 1'b1;
            st        <= S_PAY;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        S_PAY: if (in_fire) begin
          rem       <= rem - 1'b1;
          frag_left <= frag_left - 1'b1;
          if (frag_left == LEN_W'(1)) begin
            hcnt <= '0;
            st   <= (rem == LEN_W'(1)) ? S_FCS : S_HDR;
          end
        end
        S_FCS: if (in_fire && in_eop) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_hdr_stalls_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HDR) |-> (!in_ready && out_valid));

  assert_hdr_byte_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HDR && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_seq_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_q != '0);

  assert_seq_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_done && seq_q == SEQ_MAX) |=> (seq_q == SEQ_W'(1)));

  assert_frag_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PAY) |-> (frag_left != '0 && frag_left <= mtu_q && frag_left <= rem));

  assert_mtu_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && $past(st) != S_IDLE) |-> $stable(mtu_q));
endmodule

// File: tb/tb_pw_frag_encap.sv
module tb_pw_frag_encap;
  localparam int LEN_W = 16;
  localparam int SEQ_W = 8;
  localparam int MAXB  = 8192;

  logic clk = 0, rst_n = 0;
  logic [LEN_W-1:0] cfg_mtu = 100;
  logic [19:0] cfg_tun_label = 20'hABCDE, cfg_pw_label = 20'h12345;
  logic [2:0]  cfg_tun_tc = 3'd5, cfg_pw_tc = 3'd2;
  logic [7:0]  cfg_tun_ttl = 8'h40, cfg_pw_ttl = 8'hFF;
  logic in_valid = 0, in_sop = 0, in_eop = 0, out_ready = 1;
  logic [7:0] in_data = 0;
  logic [LEN_W-1:0] in_len = 0;
  logic in_ready, out_valid, out_sop, out_eop;
  logic [7:0] out_data;

  pw_frag_encap #(.LEN_W(LEN_W), .SEQ_W(SEQ_W), .PRE_LEN(8)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_mtu(cfg_mtu),
    .cfg_tun_label(cfg_tun_label), .cfg_tun_tc(cfg_tun_tc), .cfg_tun_ttl(cfg_tun_ttl),
    .cfg_pw_label(cfg_pw_label), .cfg_pw_tc(cfg_pw_tc), .cfg_pw_ttl(cfg_pw_ttl),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .in_len(in_len),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop));

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int rdy_mode = 0, cyc = 0;
  logic [7:0] cap_d [MAXB];
  logic       cap_s [MAXB], cap_e [MAXB];
  int ncap = 0, pkt_pos = 0, ir_bad = 0, hold_bad = 0;
  logic prev_stall = 0;
  logic [7:0] prev_d = 0;
  logic [7:0] exp_d [MAXB];
  logic       exp_s [MAXB], exp_e [MAXB];
  int nexp = 0;
  logic [SEQ_W-1:0] exp_seq = 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    out_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
  end

  always @(negedge clk) begin
    #2;
    if (prev_stall && (!out_valid || out_data != prev_d)) hold_bad++;
    prev_stall = out_valid && !out_ready;
    prev_d = out_data;
    if (out_valid && out_ready) begin
      if (out_sop) pkt_pos = 0;
      if (pkt_pos < 12 && in_ready) ir_bad++;
      pkt_pos++;
      if (ncap < MAXB) begin
        cap_d[ncap] = out_data; cap_s[ncap] = out_sop; cap_e[ncap] = out_eop;
      end
      ncap++;
    end
  end

  task automatic put(input logic [7:0] b, input bit s, input bit e, input int len);
    bit acc;
    in_valid = 1; in_data = b; in_sop = s; in_eop = e; in_len = LEN_W'(len);
    forever begin
      #2 acc = in_ready;
      @(negedge clk);
      if (acc) break;
    end
    in_valid = 0; in_sop = 0; in_eop = 0;
  endtask

  task automatic send_frame(input int len, input int base);
    for (int i = 0; i < 8; i++) put((i == 7) ? 8'hD5 : 8'h55, i == 0, 1'b0, len);
    for (int i = 0; i < len; i++) put(8'(base + i), 1'b0, 1'b0, len);
    for (int i = 0; i < 4; i++) put(8'hF0 + 8'(i), 1'b0, i == 3, len);
    repeat (3) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] b, input bit s, input bit e);
    exp_d[nexp] = b; exp_s[nexp] = s; exp_e[nexp] = e; nexp++;
  endtask

  task automatic push_word(input logic [31:0] w, input bit s);
    for (int k = 0; k < 4; k++) push(w[31-8*k -: 8], s && k == 0, 1'b0);
  endtask

  task automatic build(input int len, input int mtu, input int base);
    int rem = len, off = 0;
    bit frst = 1;
    logic [1:0] code;
    while (rem > 0) begin
      int n = (rem <= mtu) ? rem : mtu;
      code = frst ? ((len <= mtu) ? 2'b00 : 2'b10) : ((rem <= mtu) ? 2'b01 : 2'b11);
      push_word({cfg_tun_label, cfg_tun_tc, 1'b0, cfg_tun_ttl}, 1'b1);
      push_word({cfg_pw_label, cfg_pw_tc, 1'b1, cfg_pw_ttl}, 1'b0);
      push_word({8'h00, code, 6'h00, 16'(exp_seq)}, 1'b0);
      for (int i = 0; i < n; i++) push(8'(base + off + i), 1'b0, i == n - 1);
      exp_seq = (exp_seq == '1) ? SEQ_W'(1) : exp_seq + 1'b1;
      rem -= n; off += n; frst = 0;
    end
  endtask

  task automatic compare(input string req);
    int bad = -1;
    chk(ncap == nexp, {req, " packet byte count"}, ncap, nexp);
    for (int i = 0; i < nexp && i < ncap; i++)
      if (bad < 0 && (cap_d[i] != exp_d[i] || cap_s[i] != exp_s[i] || cap_e[i] != exp_e[i])) bad = i;
    chk(bad < 0, {req, " stream content"}, (bad < 0) ? 0 : {cap_s[bad], cap_e[bad], cap_d[bad]},
        (bad < 0) ? 0 : {exp_s[bad], exp_e[bad], exp_d[bad]});
    chk(ir_bad == 0, {req, " R10 in_ready low on header bytes"}, ir_bad, 0);
    chk(hold_bad == 0, {req, " R10 stalled byte held"}, hold_bad, 0);
  endtask

  task automatic clear();
    ncap = 0; nexp = 0; ir_bad = 0; hold_bad = 0;
  endtask

  task automatic t_reset();
    #2;
    chk(out_valid == 0, "R11 out_valid after reset", out_valid, 0);
    chk(in_ready == 1, "R11 in_ready after reset", in_ready, 1);
  endtask

  task automatic t_single();
    clear(); rdy_mode = 0; cfg_mtu = 100;
    build(20, 100, 8'h10); send_frame(20, 8'h10);
    compare("R1 R2 single frame");
    chk(cap_d[2][0] == 0, "R3 tunnel bottom-of-stack", cap_d[2][0], 0);
    chk(cap_d[6][0] == 1, "R3 pw bottom-of-stack", cap_d[6][0], 1);
    chk(cap_d[8] == 0 && cap_d[9] == 0, "R4 R5 control word upper bits unfragmented",
        {cap_d[8], cap_d[9]}, 0);
    chk({cap_d[10], cap_d[11]} == 16'd1, "R7 first sequence number", {cap_d[10], cap_d[11]}, 1);
    chk(ncap == 32 && cap_e[31], "R1 payload length and eop", ncap, 32);
  endtask

  task automatic t_frag();
    clear(); rdy_mode = 1; cfg_mtu = 10;
    build(25, 10, 8'h80); send_frame(25, 8'h80);
    compare("R5 R6 three fragments");
    chk(cap_d[9][7:6] == 2'b10 && cap_d[31][7:6] == 2'b11 && cap_d[53][7:6] == 2'b01,
        "R5 first/middle/last codes", {cap_d[9][7:6], cap_d[31][7:6], cap_d[53][7:6]}, 6'b101101);
    chk({cap_d[54], cap_d[55]} == 16'd4, "R7 per-fragment sequence", {cap_d[54], cap_d[55]}, 4);
  endtask

  task automatic t_boundary();
    clear(); rdy_mode = 1; cfg_mtu = 10;
    build(10, 10, 8'h30); send_frame(10, 8'h30);
    compare("R5 length equal to MTU");
    chk(cap_d[9][7:6] == 2'b00, "R5 exact fit is unfragmented", cap_d[9][7:6], 0);
    clear();
    build(11, 10, 8'h40); send_frame(11, 8'h40);
    compare("R6 one byte over MTU");
  endtask

  task automatic t_mtu_change();
    clear(); rdy_mode = 0; cfg_mtu = 8;
    build(20, 8, 8'hC0);
    fork
      send_frame(20, 8'hC0);
      begin repeat (2) @(negedge clk); cfg_mtu = 3; end
    join
    compare("R9 MTU change mid-frame");
    cfg_mtu = 100;
  endtask

  task automatic t_wrap();
    int k255 = -1;
    clear(); rdy_mode = 1; cfg_mtu = 1;
    build(260, 1, 8'h00); send_frame(260, 8'h00);
    compare("R8 sequence wrap");
    for (int p = 0; p < 260; p++)
      if ({cap_d[p*13+10], cap_d[p*13+11]} == 16'hFF && k255 < 0) k255 = p;
    chk(k255 >= 0 && k255 < 259, "R8 all-ones sequence seen", k255, 0);
    if (k255 >= 0 && k255 < 259)
      chk({cap_d[(k255+1)*13+10], cap_d[(k255+1)*13+11]} == 16'd1, "R8 wrap to one",
          {cap_d[(k255+1)*13+10], cap_d[(k255+1)*13+11]}, 1);
    cfg_mtu = 100;
  endtask

  bit done = 0;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    @(negedge clk);
    t_single();
    t_frag();
    t_boundary();
    t_mtu_change();
    t_wrap();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule